// File: doc/BRIEF.md
# Inbound Requester Group Classifier

This block sorts every inbound request arriving from the PCIe side into the isolation group that owns its requester. It holds a requester table that maps the 16-bit requester ID (bus, device, function) to a group number. DMA writes, MSI writes and error messages all take their group from that one table. DMA requests also report which of the group's two address windows applies. MSI requests are decoded against two MSI address windows into one of 2048 interrupt numbers. Each interrupt number has a group stored in an interrupt-owner table. An MSI is refused when that group differs from the group of the requester.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream, one cycle after acceptance. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when no result is held, or when the held result is taken in the same cycle. A result stays on `out_*` without change until `out_ready` is seen high. The refused-MSI record and the two table write ports are plain control pins.

Top module: `inbound_pe_classifier`

## Requirements
- R1: An accepted request yields `out_valid` at the next rising edge. `out_group` is the requester table entry for `in_rid`, and `out_kind` echoes the request kind (0 = DMA, 1 = MSI, 2 or 3 = error message). For error messages `out_dma_win` and `out_irq` are 0 and `out_stat` is 0.
- R2: For a DMA request (kind 0), `out_dma_win` equals bit 59 of `in_addr` and `out_irq` is 0.
- R3: An MSI address hits the low window when bits 63:16 equal 0x0000_0000_FFFF. It hits the high window when bits 63:16 equal `msi_hi_base[63:16]`. The low window wins if both match. An MSI that hits neither window gets status 1 (no window), `out_irq` 0 and no group check.
- R4: An MSI that hits a window gets interrupt number {window bit, `in_data[9:0]`}, where the window bit is 0 for the low window and 1 for the high window. Bits 31:10 of `in_data` have no effect.
- R5: An MSI that hits a window gets status 0 when the interrupt-owner table entry for its interrupt number equals the requester's group, and status 2 (refused) when it does not.
- R6: A requester ID with any bit set above the table index width (default bits 15:10) gets status 3 and `out_group` 0. Such a request never records a violation.
- R7: The first refused MSI sets `viol_flag` and stores its requester ID in `viol_rid` and its interrupt number in `viol_irq`, at the same edge its result appears. Later refusals leave all three unchanged while the flag is set.
- R8: `viol_clr` high at an edge clears `viol_flag`. A refusal accepted at that same edge is recorded, so the flag stays set.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every `out_*` signal holds its value.
- R10: After reset `out_valid` and `viol_flag` are 0. A table write at an edge is seen by any request accepted at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request will be taken this edge |
| in_kind | input | 2 | 0 DMA, 1 MSI, 2/3 error message |
| in_rid | input | 16 | Requester ID |
| in_addr | input | 64 | Request address |
| in_data | input | 32 | MSI payload |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this edge |
| out_kind | output | 2 | Kind of the classified request |
| out_rid | output | 16 | Requester ID of the result |
| out_group | output | 8 | Requester's group |
| out_dma_win | output | 1 | DMA window select |
| out_irq | output | 11 | Interrupt number |
| out_stat | output | 2 | 0 ok, 1 no window, 2 refused, 3 unmapped requester |
| msi_hi_base | input | 64 | Base of the high MSI window (bits 63:16 used) |
| rtt_we | input | 1 | Requester table write enable |
| rtt_idx | input | 10 | Requester table write index |
| rtt_grp | input | 8 | Requester table write data |
| ivt_we | input | 1 | Interrupt-owner table write enable |
| ivt_idx | input | 11 | Interrupt-owner table write index |
| ivt_grp | input | 8 | Interrupt-owner table write data |
| viol_clr | input | 1 | Clear the violation record |
| viol_flag | output | 1 | Sticky refused-MSI flag |
| viol_rid | output | 16 | Requester of the recorded refusal |
| viol_irq | output | 11 | Interrupt of the recorded refusal |

## Verification
Every result and the violation record are due exactly one rising edge after the request is accepted. A table write is due at the edge that follows it. The bench drives inputs on falling edges and holds `in_valid` for a single edge. It then reads `out_*` and the violation record at the next falling edge, half a cycle after the edge that registered them. The stall test holds `out_ready` low across several edges and checks `in_ready` and the held result at each falling edge before it releases the result.

// File: rtl/inbound_pe_pkg.sv
package inbound_pe_pkg;
  typedef enum logic [1:0] {
    RK_DMA = 2'd0,
    RK_MSI = 2'd1,
    RK_ERR = 2'd2,
    RK_ERR2 = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_NOWIN = 2'd1,
    ST_DENY  = 2'd2,
    ST_NORID = 2'd3
  } cls_stat_e;

  localparam logic [47:0] MSI_LO_TAG = 48'h0000_0000_FFFF;
endpackage

// File: rtl/grp_table.sv
module grp_table #(
  parameter int IDX_W = 10,
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [GRP_W-1:0] wgrp,
  input  logic [IDX_W-1:0] ridx,
  output logic [GRP_W-1:0] rgrp
);
  localparam int DEPTH = 1 << IDX_W;

  logic [GRP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wgrp;
  end

  assign rgrp = mem[ridx];
endmodule

// File: rtl/msi_window_dec.sv
module msi_window_dec #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] hi_base,
  input  logic [DATA_W-1:0] data,
  output logic              hit,
  output logic [IRQ_W-1:0]  irq
);
  import inbound_pe_pkg::*;
  localparam int PAGE_LSB = 16;

  logic hit_lo, hit_hi, win;

  assign hit_lo = (addr[ADDR_W-1:PAGE_LSB] == MSI_LO_TAG[ADDR_W-PAGE_LSB-1:0]);
  assign hit_hi = (addr[ADDR_W-1:PAGE_LSB] == hi_base[ADDR_W-1:PAGE_LSB]);
  assign hit    = hit_lo | hit_hi;
  assign win    = !hit_lo;
  assign irq    = hit ? {win, data[IRQ_W-2:0]} : '0;
endmodule

// File: rtl/inbound_pe_classifier.sv
module inbound_pe_classifier #(
  parameter int RID_W       = 16,
  parameter int IDX_W       = 10,
  parameter int GRP_W       = 8,
  parameter int IRQ_W       = 11,
  parameter int ADDR_W      = 64,
  parameter int DATA_W      = 32,
  parameter int DMA_SEL_BIT = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [RID_W-1:0]  in_rid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [RID_W-1:0]  out_rid,
  output logic [GRP_W-1:0]  out_group,
  output logic              out_dma_win,
  output logic [IRQ_W-1:0]  out_irq,
  output logic [1:0]        out_stat,
  input  logic [ADDR_W-1:0] msi_hi_base,
  input  logic              rtt_we,
  input  logic [IDX_W-1:0]  rtt_idx,
  input  logic [GRP_W-1:0]  rtt_grp,
  input  logic              ivt_we,
  input  logic [IRQ_W-1:0]  ivt_idx,
  input  logic [GRP_W-1:0]  ivt_grp,
  input  logic              viol_clr,
  output logic              viol_flag,
  output logic [RID_W-1:0]  viol_rid,
  output logic [IRQ_W-1:0]  viol_irq
);
  import inbound_pe_pkg::*;

  logic             accept;
  logic [GRP_W-1:0] rid_grp, irq_owner, grp_c;
  logic             msi_hit, rid_oor, win_c;
  logic [IRQ_W-1:0] msi_irq, irq_c;
  cls_stat_e        stat_c;
  req_kind_e        kind_c;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign kind_c   = req_kind_e'(in_kind);

  grp_table #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_rid_tbl (
    .clk(clk), .we(rtt_we), .widx(rtt_idx), .wgrp(rtt_grp),
    .ridx(in_rid[IDX_W-1:0]), .rgrp(rid_grp)
  );

  grp_table #(.IDX_W(IRQ_W), .GRP_W(GRP_W)) u_irq_tbl (
    .clk(clk), .we(ivt_we), .widx(ivt_idx), .wgrp(ivt_grp),
    .ridx(msi_irq), .rgrp(irq_owner)
  );

  msi_window_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_msi_dec (
    .addr(in_addr), .hi_base(msi_hi_base), .data(in_data),
    .hit(msi_hit), .irq(msi_irq)
  );

  generate
    if (RID_W > IDX_W) begin : g_range
      assign rid_oor = |in_rid[RID_W-1:IDX_W];
    end else begin : g_full
      assign rid_oor = 1'b0;
    end
  endgenerate

  always_comb begin
    grp_c  = rid_oor ? '0 : rid_grp;
    win_c  = 1'b0;
    irq_c  = '0;
    stat_c = ST_OK;
    if (rid_oor) begin
      stat_c = ST_NORID;
      if (kind_c == RK_DMA) win_c = in_addr[DMA_SEL_BIT];
      if (kind_c == RK_MSI && msi_hit) irq_c = msi_irq;
    end else begin
      unique case (kind_c)
        RK_DMA: win_c = in_addr[DMA_SEL_BIT];
        RK_MSI: begin
          if (!msi_hit) stat_c = ST_NOWIN;
          else begin
            irq_c  = msi_irq;
            stat_c = (irq_owner == rid_grp) ? ST_OK : ST_DENY;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_kind    <= '0;
      out_rid     <= '0;
      out_group   <= '0;
      out_dma_win <= 1'b0;
      out_irq     <= '0;
      out_stat    <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_kind    <= in_kind;
      out_rid     <= in_rid;
      out_group   <= grp_c;
      out_dma_win <= win_c;
      out_irq     <= irq_c;
      out_stat    <= stat_c;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_flag <= 1'b0;
      viol_rid  <= '0;
      viol_irq  <= '0;
    end else if (accept && stat_c == ST_DENY && (!viol_flag || viol_clr)) begin
      viol_flag <= 1'b1;
      viol_rid  <= in_rid;
      viol_irq  <= irq_c;
    end else if (viol_clr) begin
      viol_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/inbound_pe_classifier_chk.sv
module inbound_pe_classifier_chk #(
  parameter int RID_W = 16,
  parameter int GRP_W = 8,
  parameter int IRQ_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [GRP_W-1:0] out_group,
  input logic [IRQ_W-1:0] out_irq,
  input logic [1:0]       out_stat,
  input logic             viol_clr,
  input logic             viol_flag,
  input logic [RID_W-1:0] viol_rid,
  input logic [IRQ_W-1:0] viol_irq
);
  // R1
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_group) &&
      $stable(out_irq) && $stable(out_stat) && $stable(out_kind));

  // R5
  deny_only_msi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stat == 2'd2 |-> out_kind == 2'd1);

  // R6
  norid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_stat == 2'd3 |-> out_group == '0);

  // R7
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> out_valid && out_stat == 2'd2);

  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag && !viol_clr |=> viol_flag && $stable(viol_rid) && $stable(viol_irq));
endmodule

bind inbound_pe_classifier inbound_pe_classifier_chk #(
  .RID_W(RID_W), .GRP_W(GRP_W), .IRQ_W(IRQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_group(out_group), .out_irq(out_irq), .out_stat(out_stat),
  .viol_clr(viol_clr), .viol_flag(viol_flag), .viol_rid(viol_rid),
  .viol_irq(viol_irq)
);

// File: tb/inbound_pe_classifier_tb.sv
`timescale 1ns/1ps
module inbound_pe_classifier_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [1:0]  in_kind = 0, out_kind, out_stat;
  logic [15:0] in_rid = 0, out_rid, viol_rid;
  logic [63:0] in_addr = 0;
  logic [31:0] in_data = 0;
  logic [7:0]  out_group;
  logic        out_dma_win, viol_flag, viol_clr = 0;
  logic [10:0] out_irq, viol_irq;
  logic [63:0] msi_hi_base = 64'h0000_0040_0000_0000;
  logic        rtt_we = 0, ivt_we = 0;
  logic [9:0]  rtt_idx = 0;
  logic [10:0] ivt_idx = 0;
  logic [7:0]  rtt_grp = 0, ivt_grp = 0;

  inbound_pe_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_rid(in_rid), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_rid(out_rid), .out_group(out_group), .out_dma_win(out_dma_win),
    .out_irq(out_irq), .out_stat(out_stat), .msi_hi_base(msi_hi_base),
    .rtt_we(rtt_we), .rtt_idx(rtt_idx), .rtt_grp(rtt_grp),
    .ivt_we(ivt_we), .ivt_idx(ivt_idx), .ivt_grp(ivt_grp),
    .viol_clr(viol_clr), .viol_flag(viol_flag), .viol_rid(viol_rid),
    .viol_irq(viol_irq)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] rid;
    logic [63:0] addr;
    logic [31:0] data;
    logic [7:0]  grp;
    logic        win;
    logic [10:0] irq;
    logic [1:0]  stat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h0108, 64'h0000_0000_0000_2000, 32'h0,         8'd5,   1'b0, 11'h000, 2'd0}, // R2 win 0
    '{2'd0, 16'h0210, 64'h0800_0000_0000_1000, 32'h0,         8'd9,   1'b1, 11'h000, 2'd0}, // R2 win 1
    '{2'd1, 16'h0108, 64'h0000_0000_FFFF_0000, 32'h5,         8'd5,   1'b0, 11'h005, 2'd0}, // R3 R4 R5 low
    '{2'd1, 16'h0210, 64'h0000_0040_0000_0010, 32'h5,         8'd9,   1'b0, 11'h405, 2'd0}, // R3 R4 R5 high
    '{2'd1, 16'h0108, 64'h0000_0000_FFFF_0004, 32'hFFFF_FC05, 8'd5,   1'b0, 11'h005, 2'd0}, // R4 high data ignored
    '{2'd1, 16'h0210, 64'h0000_0000_FFFF_0000, 32'h5,         8'd9,   1'b0, 11'h005, 2'd2}, // R5 refused
    '{2'd1, 16'h0108, 64'h0000_0000_8000_0000, 32'h5,         8'd5,   1'b0, 11'h000, 2'd1}, // R3 no window
    '{2'd2, 16'h03FF, 64'h0,                   32'h0,         8'd200, 1'b0, 11'h000, 2'd0}, // R1 error msg
    '{2'd0, 16'h0408, 64'h0800_0000_0000_0000, 32'h0,         8'd0,   1'b1, 11'h000, 2'd3}  // R6 unmapped
  };

  task automatic send(input logic [1:0] k, input logic [15:0] r, input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1; in_kind = k; in_rid = r; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr_rtt(input logic [9:0] i, input logic [7:0] g);
    @(negedge clk); rtt_we = 1; rtt_idx = i; rtt_grp = g;
    @(negedge clk); rtt_we = 0;
  endtask

  task automatic wr_ivt(input logic [10:0] i, input logic [7:0] g);
    @(negedge clk); ivt_we = 1; ivt_idx = i; ivt_grp = g;
    @(negedge clk); ivt_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 0, "R10 out_valid after reset", 64'(out_valid), 0);
    chk(viol_flag == 0, "R10 viol_flag after reset", 64'(viol_flag), 0);
    rst_n = 1;
    wr_rtt(10'h108, 8'd5);
    wr_rtt(10'h210, 8'd9);
    wr_rtt(10'h3FF, 8'd200);
    wr_ivt(11'h005, 8'd5);
    wr_ivt(11'h405, 8'd9);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].kind, VEC[i].rid, VEC[i].addr, VEC[i].data);
      chk(out_valid && out_kind == VEC[i].kind && out_rid == VEC[i].rid &&
          {out_group, out_dma_win, out_irq, out_stat} ==
          {VEC[i].grp, VEC[i].win, VEC[i].irq, VEC[i].stat},
          $sformatf("R1 vector %0d", i),
          64'({out_valid, out_group, out_dma_win, out_irq, out_stat}),
          64'({1'b1, VEC[i].grp, VEC[i].win, VEC[i].irq, VEC[i].stat}));
    end

    // R7 recorded first refusal (vector 5)
    chk(viol_flag && viol_rid == 16'h0210 && viol_irq == 11'h005, "R7 first refusal record",
        64'({viol_flag, viol_rid, viol_irq}), 64'({1'b1, 16'h0210, 11'h005}));
    // R7 second refusal with other requester/irq leaves record unchanged
    send(2'd1, 16'h0108, 64'h0000_0040_0000_0000, 32'h5);
    chk(out_stat == 2'd2 && out_irq == 11'h405, "R5 refused high window", 64'({out_stat, out_irq}), 64'({2'd2, 11'h405}));
    chk(viol_flag && viol_rid == 16'h0210 && viol_irq == 11'h005, "R7 sticky record",
        64'({viol_flag, viol_rid, viol_irq}), 64'({1'b1, 16'h0210, 11'h005}));
    // R8 clear
    @(negedge clk); viol_clr = 1;
    @(negedge clk); viol_clr = 0;
    chk(viol_flag == 0, "R8 clear", 64'(viol_flag), 0);
    // R6 unmapped MSI refused-looking never records
    send(2'd1, 16'h8210, 64'h0000_0000_FFFF_0000, 32'h5);
    chk(out_stat == 2'd3 && viol_flag == 0, "R6 unmapped no violation", 64'({out_stat, viol_flag}), 64'({2'd3, 1'b0}));
    // R8 clear and refusal at the same edge: refusal recorded
    @(negedge clk);
    viol_clr = 1; in_valid = 1; in_kind = 2'd1; in_rid = 16'h0108;
    in_addr = 64'h0000_0040_0000_0000; in_data = 32'h5;
    @(negedge clk); viol_clr = 0; in_valid = 0;
    chk(viol_flag && viol_rid == 16'h0108 && viol_irq == 11'h405, "R8 set wins over clear",
        64'({viol_flag, viol_rid, viol_irq}), 64'({1'b1, 16'h0108, 11'h405}));
    // R10 table write then immediate use
    wr_ivt(11'h405, 8'd5);
    send(2'd1, 16'h0108, 64'h0000_0040_0000_0000, 32'h5);
    chk(out_stat == 2'd0, "R10 new owner seen", 64'(out_stat), 0);

    // R9 back-pressure
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_kind = 2'd2; in_rid = 16'h03FF; in_addr = 0; in_data = 0;
    @(negedge clk);
    in_kind = 2'd0; in_rid = 16'h0210; in_addr = 64'h0800_0000_0000_0000;
    chk(out_valid && !in_ready, "R9 stall in_ready low", 64'({out_valid, in_ready}), 64'({1'b1, 1'b0}));
    @(negedge clk);
    chk(out_valid && out_group == 8'd200 && out_kind == 2'd2 && !in_ready, "R9 held result",
        64'({out_kind, out_group}), 64'({2'd2, 8'd200}));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid && out_group == 8'd9 && out_dma_win, "R9 next after release",
        64'({out_group, out_dma_win}), 64'({8'd9, 1'b1}));
    @(negedge clk);
    chk(!out_valid, "R9 drained", 64'(out_valid), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule